// File: doc/BRIEF.md
# Integer Execution Unit (64-bit operate class)

This block is the integer execute stage of a 64-bit load/store core. Each cycle it may accept one operation: a 5-bit operation code, a first operand, and a second operand taken from a register value or from an 8-bit unsigned immediate. The choice between the two follows a single format flag. One clock edge later it presents a 64-bit result together with a result-valid strobe that the writeback stage uses as its register-file write enable.

The operation set covers several groups. Addition, subtraction and multiplication come in both 32-bit and 64-bit widths. Scaled add and subtract shift the second operand left by two or three places before the operation. The unit also provides signed 64-bit comparisons yielding 0 or 1, six bitwise forms including the complemented ones, and conditional moves that test the first operand against zero. A conditional move whose test fails drops the strobe, so the destination keeps its old value. No divide is provided, and the unused operation codes also produce no strobe.

Top module: `int_exec_unit`

## Requirements
- R1: Op codes 1 (add) and 3 (subtract, first minus second) return the 64-bit sum or difference modulo 2^64.
- R2: Op codes 0 (add), 2 (subtract), 4 (multiply), 6 and 7 (add, second operand times 4 / 8), 10 and 11 (subtract, second operand times 4 / 8) take the low 32 bits of the 64-bit result and sign-extend bit 31 into bits 63:32.
- R3: Op code 5 returns the low 64 bits of the product of the two operands.
- R4: Op codes 8 and 9 return first + (second << 2) and first + (second << 3); op codes 12 and 13 return first - (second << 2) and first - (second << 3), all 64-bit.
- R5: Op codes 14 (equal), 15 (signed less than) and 16 (signed less or equal) compare both operands as signed 64-bit values and return 1 when true, else 0.
- R6: Op codes 17 AND, 18 NAND, 19 OR, 20 NOR, 21 XOR, 22 XNOR return the bitwise function of the two operands.
- R7: With the format flag `use_lit` at 0 the second operand is `opb_reg`; at 1 it is `lit` zero-extended to 64 bits and `opb_reg` has no effect on the result.
- R8: Op codes 23 (first == 0), 24 (!= 0), 25 (< 0), 26 (<= 0), 27 (>= 0), 28 (> 0), with the first operand read as signed 64-bit, return the second operand with the strobe high when the test holds.
- R9: When a conditional-move test fails, `res_valid` stays low.
- R10: `res_valid` rises exactly one cycle after an accepted `in_valid`, and is low in a cycle following one with `in_valid` low.
- R11: Op codes 29 to 31 (including any divide request) produce no strobe.
- R12: During reset `res_valid` and `res_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Operation code |
| opa | input | 64 | First operand |
| opb_reg | input | 64 | Register second operand |
| lit | input | 8 | Unsigned immediate second operand |
| use_lit | input | 1 | Format flag: 1 selects the immediate |
| res_valid | output | 1 | Result strobe / write enable |
| res_data | output | 64 | Result |

## Verification
Every result and strobe is due exactly one rising edge after the cycle in which the operation was presented. This holds for every group; no operation takes longer. The bench drives each operation on a falling edge and reads the outputs on the next falling edge, half a period after the registering edge, then drives the next operation at the same instant. Strobe suppression for failed moves and unused codes is judged at that same sample point. One idle cycle confirms that the strobe does not persist.

// File: rtl/iex_pkg.sv
package iex_pkg;
   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD_W   = 5'd0,
      OP_ADD_D   = 5'd1,
      OP_SUB_W   = 5'd2,
      OP_SUB_D   = 5'd3,
      OP_MUL_W   = 5'd4,
      OP_MUL_D   = 5'd5,
      OP_ADD4_W  = 5'd6,
      OP_ADD8_W  = 5'd7,
      OP_ADD4_D  = 5'd8,
      OP_ADD8_D  = 5'd9,
      OP_SUB4_W  = 5'd10,
      OP_SUB8_W  = 5'd11,
      OP_SUB4_D  = 5'd12,
      OP_SUB8_D  = 5'd13,
      OP_CEQ     = 5'd14,
      OP_CLT     = 5'd15,
      OP_CLE     = 5'd16,
      OP_AND     = 5'd17,
      OP_NAND    = 5'd18,
      OP_OR      = 5'd19,
      OP_NOR     = 5'd20,
      OP_XOR     = 5'd21,
      OP_XNOR    = 5'd22,
      OP_MV_EQ   = 5'd23,
      OP_MV_NE   = 5'd24,
      OP_MV_LT   = 5'd25,
      OP_MV_LE   = 5'd26,
      OP_MV_GE   = 5'd27,
      OP_MV_GT   = 5'd28,
      OP_RSV_29  = 5'd29,
      OP_RSV_30  = 5'd30,
      OP_RSV_31  = 5'd31
   } iex_op_e;

   function automatic logic is_word_op(input logic [OP_W-1:0] o);
      return (o == OP_ADD_W) || (o == OP_SUB_W) || (o == OP_MUL_W) ||
             (o == OP_ADD4_W) || (o == OP_ADD8_W) ||
             (o == OP_SUB4_W) || (o == OP_SUB8_W);
   endfunction
endpackage

// File: rtl/iex_operand_sel.sv
module iex_operand_sel #(
   parameter int XLEN  = 64,
   parameter int LIT_W = 8
) (
   input  logic [XLEN-1:0]  opb_reg,
   input  logic [LIT_W-1:0] lit,
   input  logic             use_lit,
   output logic [XLEN-1:0]  opb
);
   localparam int PAD_W = XLEN - LIT_W;

   logic [XLEN-1:0] lit_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign lit_ext = {{PAD_W{1'b0}}, lit};
      end else begin : g_nopad
         assign lit_ext = lit[XLEN-1:0];
      end
   endgenerate

   assign opb = use_lit ? lit_ext : opb_reg;
endmodule

// File: rtl/iex_arith.sv
module iex_arith
   import iex_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int WLEN = 32
) (
   input  logic [OP_W-1:0] op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            hit,
   output logic [XLEN-1:0] res
);
   localparam int EXT_W = XLEN - WLEN;

   logic [XLEN-1:0] b_sc;
   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] dif;
   logic [XLEN-1:0] prod;
   logic [XLEN-1:0] raw;
   logic [XLEN-1:0] narrow;
   logic            lt_s;
   logic            eq;

   always_comb begin
      unique case (iex_op_e'(op))
         OP_ADD4_W, OP_ADD4_D, OP_SUB4_W, OP_SUB4_D: b_sc = b << 2;
         OP_ADD8_W, OP_ADD8_D, OP_SUB8_W, OP_SUB8_D: b_sc = b << 3;
         default:                                   b_sc = b;
      endcase
   end

   assign sum  = a + b_sc;
   assign dif  = a - b_sc;
   assign prod = a * b;
   assign lt_s = $signed(a) < $signed(b);
   assign eq   = (a == b);

   always_comb begin
      hit = 1'b1;
      raw = '0;
      unique case (iex_op_e'(op))
         OP_ADD_W, OP_ADD_D, OP_ADD4_W, OP_ADD8_W,
         OP_ADD4_D, OP_ADD8_D:                      raw = sum;
         OP_SUB_W, OP_SUB_D, OP_SUB4_W, OP_SUB8_W,
         OP_SUB4_D, OP_SUB8_D:                      raw = dif;
         OP_MUL_W, OP_MUL_D:                        raw = prod;
         OP_CEQ:                                    raw = {{(XLEN-1){1'b0}}, eq};
         OP_CLT:                                    raw = {{(XLEN-1){1'b0}}, lt_s};
         OP_CLE:                                    raw = {{(XLEN-1){1'b0}}, lt_s | eq};
         default:                                   hit = 1'b0;
      endcase
   end

   generate
      if (EXT_W > 0) begin : g_sext
         assign narrow = {{EXT_W{raw[WLEN-1]}}, raw[WLEN-1:0]};
      end else begin : g_full
         assign narrow = raw;
      end
   endgenerate

   assign res = is_word_op(op) ? narrow : raw;
endmodule

// File: rtl/iex_logic.sv
module iex_logic
   import iex_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [OP_W-1:0] op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            hit,
   output logic [XLEN-1:0] res
);
   logic [XLEN-1:0] base;
   logic            inv;

   always_comb begin
      hit  = 1'b1;
      inv  = 1'b0;
      base = '0;
      unique case (iex_op_e'(op))
         OP_AND:  base = a & b;
         OP_NAND: begin base = a & b; inv = 1'b1; end
         OP_OR:   base = a | b;
         OP_NOR:  begin base = a | b; inv = 1'b1; end
         OP_XOR:  base = a ^ b;
         OP_XNOR: begin base = a ^ b; inv = 1'b1; end
         default: hit = 1'b0;
      endcase
   end

   assign res = inv ? ~base : base;
endmodule

// File: rtl/iex_cmov.sv
module iex_cmov
   import iex_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [OP_W-1:0] op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic            hit,
   output logic            take,
   output logic [XLEN-1:0] res
);
   logic zero;
   logic neg;

   assign zero = (a == '0);
   assign neg  = a[XLEN-1];

   always_comb begin
      hit  = 1'b1;
      take = 1'b0;
      unique case (iex_op_e'(op))
         OP_MV_EQ: take = zero;
         OP_MV_NE: take = !zero;
         OP_MV_LT: take = neg;
         OP_MV_LE: take = neg | zero;
         OP_MV_GE: take = !neg;
         OP_MV_GT: take = !neg & !zero;
         default:  hit  = 1'b0;
      endcase
   end

   assign res = b;
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
   import iex_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int WLEN  = 32,
   parameter int LIT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [4:0]       op,
   input  logic [XLEN-1:0]  opa,
   input  logic [XLEN-1:0]  opb_reg,
   input  logic [LIT_W-1:0] lit,
   input  logic             use_lit,
   output logic             res_valid,
   output logic [XLEN-1:0]  res_data
);
   generate
      if (WLEN < 4 || WLEN > XLEN) begin : g_bad_wlen
         $error("int_exec_unit: WLEN must lie in 4..XLEN");
      end
      if (LIT_W < 1 || LIT_W > XLEN) begin : g_bad_lit
         $error("int_exec_unit: LIT_W must lie in 1..XLEN");
      end
   endgenerate

   logic [XLEN-1:0] opb;
   logic            ar_hit, lg_hit, mv_hit, mv_take;
   logic [XLEN-1:0] ar_res, lg_res, mv_res;
   logic            nxt_valid;
   logic [XLEN-1:0] nxt_data;

   iex_operand_sel #(.XLEN(XLEN), .LIT_W(LIT_W)) u_sel (
      .opb_reg (opb_reg),
      .lit     (lit),
      .use_lit (use_lit),
      .opb     (opb)
   );

   iex_arith #(.XLEN(XLEN), .WLEN(WLEN)) u_arith (
      .op  (op),
      .a   (opa),
      .b   (opb),
      .hit (ar_hit),
      .res (ar_res)
   );

   iex_logic #(.XLEN(XLEN)) u_logic (
      .op  (op),
      .a   (opa),
      .b   (opb),
      .hit (lg_hit),
      .res (lg_res)
   );

   iex_cmov #(.XLEN(XLEN)) u_cmov (
      .op   (op),
      .a    (opa),
      .b    (opb),
      .hit  (mv_hit),
      .take (mv_take),
      .res  (mv_res)
   );

   always_comb begin
      nxt_valid = in_valid & (ar_hit | lg_hit | (mv_hit & mv_take));
      if (ar_hit)      nxt_data = ar_res;
      else if (lg_hit) nxt_data = lg_res;
      else             nxt_data = mv_res;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
      end else begin
         res_valid <= nxt_valid;
         if (nxt_valid) res_data <= nxt_data;
      end
   end
endmodule

// File: rtl/iex_chk.sv
module iex_chk #(
   parameter int XLEN  = 64,
   parameter int WLEN  = 32,
   parameter int LIT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [4:0]       op,
   input logic [XLEN-1:0]  opa,
   input logic [XLEN-1:0]  opb_reg,
   input logic [LIT_W-1:0] lit,
   input logic             use_lit,
   input logic             res_valid,
   input logic [XLEN-1:0]  res_data
);
   logic word_op;
   logic [XLEN-1:0] lit_z;
   assign word_op = iex_pkg::is_word_op(op);
   assign lit_z   = XLEN'(lit);

   // R12
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !res_valid && res_data == '0);

   // R10
   strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(in_valid));

   // R2
   word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && word_op |=> res_valid && res_data[XLEN-1:WLEN] == {(XLEN-WLEN){res_data[WLEN-1]}});

   // R5
   cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op >= 5'd14 && op <= 5'd16 |=> res_valid && res_data[XLEN-1:1] == '0);

   // R9
   mv_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == 5'd23 && opa != '0 |=> !res_valid);

   // R8
   mv_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == 5'd27 && !opa[XLEN-1] |=>
      res_valid && res_data == ($past(use_lit) ? $past(lit_z) : $past(opb_reg)));

   // R11
   unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op >= 5'd29 |=> !res_valid);
endmodule

bind int_exec_unit iex_chk #(.XLEN(XLEN), .WLEN(WLEN), .LIT_W(LIT_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op        (op),
   .opa       (opa),
   .opb_reg   (opb_reg),
   .lit       (lit),
   .use_lit   (use_lit),
   .res_valid (res_valid),
   .res_data  (res_data)
);

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  op = '0;
   logic [63:0] opa = '0;
   logic [63:0] opb_reg = '0;
   logic [7:0]  lit = '0;
   logic        use_lit = 1'b0;
   logic        res_valid;
   logic [63:0] res_data;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   int_exec_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .opa(opa),
      .opb_reg(opb_reg), .lit(lit), .use_lit(use_lit),
      .res_valid(res_valid), .res_data(res_data)
   );

   function automatic logic [63:0] sx(input logic [63:0] v);
      return {{32{v[31]}}, v[31:0]};
   endfunction

   function automatic string tag_of(input int o);
      if (o == 1 || o == 3) return "R1";
      if (o == 0 || o == 2 || o == 4 || o == 6 || o == 7 || o == 10 || o == 11) return "R2";
      if (o == 5) return "R3";
      if (o >= 8 && o <= 13) return "R4";
      if (o >= 14 && o <= 16) return "R5";
      if (o >= 17 && o <= 22) return "R6";
      if (o >= 23 && o <= 28) return "R8/R9";
      return "R11";
   endfunction

   task automatic model(input int o, input logic [63:0] a, input logic [63:0] b,
                        output bit v, output logic [63:0] d);
      logic signed [63:0] sa, sb;
      sa = a; sb = b; v = 1'b1; d = '0;
      case (o)
         0:  d = sx(a + b);
         1:  d = a + b;
         2:  d = sx(a - b);
         3:  d = a - b;
         4:  d = sx(a * b);
         5:  d = a * b;
         6:  d = sx(a + b * 4);
         7:  d = sx(a + b * 8);
         8:  d = a + b * 4;
         9:  d = a + b * 8;
         10: d = sx(a - b * 4);
         11: d = sx(a - b * 8);
         12: d = a - b * 4;
         13: d = a - b * 8;
         14: d = (a == b) ? 64'd1 : 64'd0;
         15: d = (sa < sb) ? 64'd1 : 64'd0;
         16: d = (sa <= sb) ? 64'd1 : 64'd0;
         17: d = a & b;
         18: d = ~(a & b);
         19: d = a | b;
         20: d = ~(a | b);
         21: d = a ^ b;
         22: d = ~(a ^ b);
         23: begin v = (sa == 0); d = b; end
         24: begin v = (sa != 0); d = b; end
         25: begin v = (sa < 0);  d = b; end
         26: begin v = (sa <= 0); d = b; end
         27: begin v = (sa >= 0); d = b; end
         28: begin v = (sa > 0);  d = b; end
         default: v = 1'b0;
      endcase
   endtask

   task automatic expect_out(input string tag, input bit ev, input logic [63:0] ed);
      n_cmp++;
      if (res_valid !== ev || (ev && res_data !== ed)) begin
         n_bad++;
         $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                  tag, res_valid, res_data, ev, ed);
      end
   endtask

   logic [63:0] pats [8];
   logic [7:0]  lits [5];

   initial begin
      pats[0] = 64'h0;
      pats[1] = 64'h1;
      pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[3] = 64'h0000_0000_7FFF_FFFF;
      pats[4] = 64'h0000_0000_8000_0000;
      pats[5] = 64'h8000_0000_0000_0000;
      pats[6] = 64'h1234_5678_9ABC_DEF0;
      pats[7] = 64'hFFFF_FFFF_0000_0005;
      lits[0] = 8'h00; lits[1] = 8'h01; lits[2] = 8'h7F; lits[3] = 8'hFF; lits[4] = 8'hA5;

      repeat (3) @(negedge clk);
      // R12: outputs cleared while reset is held
      expect_out("R12", 1'b0, 64'h0);
      if (res_data !== 64'h0) begin
         n_bad++;
         $display("FAIL R12: data=%h expected 0", res_data);
      end
      rst_n = 1'b1;

      for (int o = 0; o < 32; o++) begin
         for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
               for (int ul = 0; ul < 2; ul++) begin
                  bit ev;
                  logic [63:0] ed, bsel;
                  string t;
                  op = 5'(o);
                  opa = pats[ia];
                  opb_reg = pats[ib];
                  lit = lits[ib % 5];
                  use_lit = ul[0];
                  in_valid = 1'b1;
                  bsel = ul[0] ? {56'h0, lits[ib % 5]} : pats[ib];
                  model(o, pats[ia], bsel, ev, ed);
                  t = ul[0] ? {tag_of(o), "+R7"} : tag_of(o);
                  @(negedge clk);
                  expect_out(t, ev, ed);
               end
            end
         end
      end

      // R10: strobe drops after an idle cycle, then returns one cycle after a new op
      in_valid = 1'b0;
      @(negedge clk);
      expect_out("R10", 1'b0, 64'h0);
      op = 5'd1; opa = 64'd40; opb_reg = 64'd2; use_lit = 1'b0; in_valid = 1'b1;
      @(negedge clk);
      expect_out("R10", 1'b1, 64'd42);
      in_valid = 1'b0;
      @(negedge clk);
      expect_out("R10", 1'b0, 64'h0);

      // R7: register operand ignored when immediate selected
      op = 5'd19; opa = 64'h0; opb_reg = 64'hDEAD_BEEF_0000_0000; lit = 8'h3C;
      use_lit = 1'b1; in_valid = 1'b1;
      @(negedge clk);
      expect_out("R7", 1'b1, 64'h3C);
      in_valid = 1'b0;

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule